// File: doc/BRIEF.md
# Multi-Format Page Table Walker

This block services a translation miss in hardware. When it is idle and sees a start pulse, it takes a virtual address, the access kind (fetch, write, user) and the current paging configuration. It then reads page table entries from memory one level at a time. When it reaches a leaf it hands a complete mapping to the TLB through a one-cycle fill strobe. One state machine covers four table formats: four-level 64-bit tables, three-level PAE tables, and two-level 32-bit tables with or without large pages.

On every level that carries access bits, the walker sets the entry's accessed bit. It writes the entry back to memory only when that bit was clear. It folds the writable and user permissions of all visited levels into the installed mapping. A missing entry, or an instruction fetch through an entry marked no-execute, ends the walk with a page fault report instead of a fill. Memory is reached through a plain request/acknowledge port: the request is held until it is acknowledged, and read data comes with the acknowledge.

Top module: `pgw_top`

## Requirements
- R1: While reset is low and in the cycle after it rises, `ready_o` is 1 and `mem_req_o`, `done_o` and `fill_valid_o` are 0.
- R2: In mode 3 (64-bit), the walk reads four 8-byte entries. The first is at `root_i[51:12]<<12` plus VA[47:39]*8. Each following entry is at the previous entry's bits 51:12 shifted by 12, plus VA[38:30], VA[29:21] and VA[20:12] times 8 in turn.
- R3: A directory-level entry (third level in mode 3, second in mode 2) with bit 7 set ends the walk with a 2 MB page (size code 1). In mode 1 such an entry ends it with a 4 MB page (size code 2, base bits 31:22). In mode 0, bit 7 is ignored and the walk continues to a 4 KB page (size code 0).
- R4: In mode 2 (PAE), the first entry is at `root_i[31:5]<<5` plus VA[31:30]*8. That entry is checked only for present. It is never written back and does not take part in permissions or no-execute.
- R5: In modes 0 and 1 (32-bit), entries are 4 bytes wide and taken from read-data bits 31:0. The indices are VA[31:22] and VA[21:12]. The frame field is bits 31:12.
- R6: An entry whose accessed bit (bit 5) is clear is written back before the walk moves on: to the address it was read from, with bit 5 set. Entries with bit 5 already set, PAE first-level entries and faulting entries are never written.
- R7: The installed writable (bit 1) and user (bit 2) flags are the AND over all permission-bearing levels visited. The installed no-execute flag is the OR of bit 63 over those levels while no-execute is enabled, and 0 otherwise.
- R8: An entry with bit 0 clear ends the walk with a fault: `flt_present_o`=0, and `flt_write_o`/`flt_user_o` equal to the access's write and user flags. No fill is issued.
- R9: No-execute is enabled only when `nx_en_i` is 1 in mode 2 or 3. A fetch through an entry with bit 63 set then faults with `flt_present_o`=1. `flt_fetch_o` is the fetch flag ANDed with that enable.
- R10: The installed global flag is leaf bit 8. The PAT flag is leaf bit 12 for large pages and bit 7 for 4 KB pages. `fill_vpage_o` is the address aligned down to the page size, with VA[47:32] zeroed in modes 0 to 2.
- R11: Root bit 4 (cache disable) drives `mem_uc_o` on every access of the walk and is installed as `fill_uc_o`.
- R12: A walk ends with `done_o` high for exactly one cycle while `ready_o` is already 1. `fill_valid_o` is high in that cycle only when there is no fault. `start_i` is ignored while a walk is in progress.
- R13: Once raised, `mem_req_o`, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` hold steady until `mem_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a walk (taken when ready) |
| mode_i | input | 2 | 0 legacy 4 KB, 1 legacy with large pages, 2 PAE, 3 64-bit |
| root_i | input | 64 | Table root register value |
| nx_en_i | input | 1 | Extended-features no-execute enable |
| va_i | input | 48 | Virtual address to translate |
| fetch_i | input | 1 | Access is an instruction fetch |
| write_i | input | 1 | Access is a write |
| user_i | input | 1 | Access is from user mode |
| ready_o | output | 1 | Walker idle |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write-back |
| mem_uc_o | output | 1 | Request is uncacheable |
| mem_addr_o | output | 52 | Entry byte address |
| mem_wdata_o | output | 64 | Write-back data |
| mem_ack_i | input | 1 | Request accepted; read data valid |
| mem_rdata_i | input | 64 | Read data |
| done_o | output | 1 | Walk finished (one cycle) |
| fault_o | output | 1 | Walk ended in a page fault |
| flt_present_o | output | 1 | Fault: faulting entry was present |
| flt_write_o | output | 1 | Fault: write access |
| flt_user_o | output | 1 | Fault: user access |
| flt_fetch_o | output | 1 | Fault: fetch with no-execute enabled |
| fill_valid_o | output | 1 | TLB install strobe |
| fill_vpage_o | output | 48 | Aligned virtual page |
| fill_ppage_o | output | 52 | Physical page base |
| fill_size_o | output | 2 | 0 4 KB, 1 2 MB, 2 4 MB |
| fill_wr_o | output | 1 | Mapping writable |
| fill_user_o | output | 1 | Mapping user accessible |
| fill_nx_o | output | 1 | Mapping no-execute |
| fill_global_o | output | 1 | Mapping global |
| fill_pat_o | output | 1 | PAT attribute bit |
| fill_uc_o | output | 1 | Mapping uncacheable |

## Verification
The bench builds the walker with its default widths: a 48-bit virtual address, 52-bit physical addresses and 64-bit entries. At these widths every index field of the four-level format is exercised, and a 40-bit frame number is carried through each level. The upper virtual bits can also be seen being discarded in the 32-bit formats. The tables are laid out so that a wrong index slice or a wrong entry stride reads an unpopulated word, which the memory model counts.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    localparam int VA_W   = 48;
    localparam int PA_W   = 52;
    localparam int ENT_W  = 64;
    localparam int PG_SH  = 12;
    localparam int IDX_W  = 10;

    localparam int BIT_P     = 0;
    localparam int BIT_W     = 1;
    localparam int BIT_U     = 2;
    localparam int BIT_CD    = 4;
    localparam int BIT_A     = 5;
    localparam int BIT_PS    = 7;
    localparam int BIT_G     = 8;
    localparam int BIT_PAT_L = 12;
    localparam int BIT_PAT_S = 7;
    localparam int BIT_NX    = 63;

    typedef enum logic [1:0] {
        MD_LEG     = 2'd0,
        MD_LEG_BIG = 2'd1,
        MD_PAE     = 2'd2,
        MD_LONG    = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        LV_PT  = 2'd0,
        LV_PD  = 2'd1,
        LV_PDP = 2'd2,
        LV_TOP = 2'd3
    } lvl_e;

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_4M = 2'd2
    } psz_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RD   = 2'd1,
        S_WB   = 2'd2
    } st_e;

    function automatic lvl_e first_lvl(mode_e m);
        case (m)
            MD_LONG: return LV_TOP;
            MD_PAE:  return LV_PDP;
            default: return LV_PD;
        endcase
    endfunction

    function automatic logic [PA_W-1:0] root_base(mode_e m, logic [ENT_W-1:0] r);
        case (m)
            MD_LONG: return {r[PA_W-1:PG_SH], {PG_SH{1'b0}}};
            MD_PAE:  return PA_W'({r[31:5], 5'b0});
            default: return PA_W'({r[31:PG_SH], {PG_SH{1'b0}}});
        endcase
    endfunction

    function automatic logic [VA_W-1:0] page_mask(psz_e s);
        case (s)
            PG_2M:   return {{(VA_W-21){1'b1}}, 21'b0};
            PG_4M:   return {{(VA_W-22){1'b1}}, 22'b0};
            default: return {{(VA_W-PG_SH){1'b1}}, {PG_SH{1'b0}}};
        endcase
    endfunction

endpackage

// File: rtl/pgw_addr.sv
module pgw_addr
    import pgw_pkg::*;
(
    input  mode_e             mode,
    input  lvl_e              lvl,
    input  logic [VA_W-1:0]   va,
    input  logic [PA_W-1:0]   base,
    output logic [PA_W-1:0]   addr
);

    logic [IDX_W-1:0] idx;
    logic             wide;

    always_comb begin
        idx  = '0;
        wide = (mode == MD_LONG) || (mode == MD_PAE);
        case (mode)
            MD_LONG: begin
                case (lvl)
                    LV_TOP:  idx = IDX_W'(va[47:39]);
                    LV_PDP:  idx = IDX_W'(va[38:30]);
                    LV_PD:   idx = IDX_W'(va[29:21]);
                    default: idx = IDX_W'(va[20:12]);
                endcase
            end
            MD_PAE: begin
                case (lvl)
                    LV_PDP:  idx = IDX_W'(va[31:30]);
                    LV_PD:   idx = IDX_W'(va[29:21]);
                    LV_PT:   idx = IDX_W'(va[20:12]);
                    default: idx = '0;
                endcase
            end
            default: begin
                case (lvl)
                    LV_PD:   idx = va[31:22];
                    LV_PT:   idx = va[21:12];
                    default: idx = '0;
                endcase
            end
        endcase
        addr = base + (PA_W'(idx) << (wide ? 3 : 2));
    end

endmodule

// File: rtl/pgw_eval.sv
module pgw_eval
    import pgw_pkg::*;
(
    input  mode_e             mode,
    input  lvl_e              lvl,
    input  logic [ENT_W-1:0]  raw,
    input  logic              nx_on,
    input  logic              fetch,
    output logic              present,
    output logic              fault,
    output logic              leaf,
    output psz_e              psz,
    output logic              perm_lvl,
    output logic              need_wb,
    output logic              ent_w,
    output logic              ent_u,
    output logic              ent_nx,
    output logic              ent_g,
    output logic              ent_pat,
    output logic [PA_W-1:0]   next_base,
    output logic [PA_W-1:0]   page_base,
    output logic [ENT_W-1:0]  wb_data
);

    logic [ENT_W-1:0] ent;
    logic             legacy;
    logic             big;
    logic             nx_hit;

    always_comb begin
        legacy    = (mode == MD_LEG) || (mode == MD_LEG_BIG);
        ent       = legacy ? ENT_W'(raw[31:0]) : raw;
        perm_lvl  = !((mode == MD_PAE) && (lvl == LV_PDP));
        present   = ent[BIT_P];
        nx_hit    = nx_on && fetch && ent[BIT_NX] && perm_lvl;
        fault     = !present || nx_hit;
        big       = ent[BIT_PS] && (lvl == LV_PD) && (mode != MD_LEG);
        leaf      = (lvl == LV_PT) || big;
        if (!big)        psz = PG_4K;
        else if (legacy) psz = PG_4M;
        else             psz = PG_2M;
        need_wb   = perm_lvl && !ent[BIT_A] && !fault;
        ent_w     = ent[BIT_W];
        ent_u     = ent[BIT_U];
        ent_nx    = nx_on && ent[BIT_NX];
        ent_g     = ent[BIT_G];
        ent_pat   = big ? ent[BIT_PAT_L] : ent[BIT_PAT_S];
        next_base = legacy ? PA_W'({ent[31:PG_SH], {PG_SH{1'b0}}})
                           : {ent[PA_W-1:PG_SH], {PG_SH{1'b0}}};
        case (psz)
            PG_2M:   page_base = {ent[PA_W-1:21], 21'b0};
            PG_4M:   page_base = PA_W'({ent[31:22], 22'b0});
            default: page_base = next_base;
        endcase
        wb_data   = ent | (ENT_W'(1) << BIT_A);
    end

endmodule

// File: rtl/pgw_top.sv
module pgw_top
    import pgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [63:0]       root_i,
    input  logic              nx_en_i,
    input  logic [47:0]       va_i,
    input  logic              fetch_i,
    input  logic              write_i,
    input  logic              user_i,
    output logic              ready_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic              mem_uc_o,
    output logic [51:0]       mem_addr_o,
    output logic [63:0]       mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [63:0]       mem_rdata_i,
    output logic              done_o,
    output logic              fault_o,
    output logic              flt_present_o,
    output logic              flt_write_o,
    output logic              flt_user_o,
    output logic              flt_fetch_o,
    output logic              fill_valid_o,
    output logic [47:0]       fill_vpage_o,
    output logic [51:0]       fill_ppage_o,
    output logic [1:0]        fill_size_o,
    output logic              fill_wr_o,
    output logic              fill_user_o,
    output logic              fill_nx_o,
    output logic              fill_global_o,
    output logic              fill_pat_o,
    output logic              fill_uc_o
);

    typedef struct packed {
        st_e               st;
        mode_e             mode;
        lvl_e              lvl;
        logic [VA_W-1:0]   va;
        logic [PA_W-1:0]   addr;
        logic [ENT_W-1:0]  wdata;
        logic [PA_W-1:0]   nxt_addr;
        lvl_e              nxt_lvl;
        logic              wb_last;
        logic              fetch;
        logic              wr;
        logic              usr;
        logic              nx_on;
        logic              uc;
        logic              acc_w;
        logic              acc_u;
        logic              acc_nx;
        logic              done;
        logic              fault;
        logic              f_present;
        logic              f_fetch;
        logic [VA_W-1:0]   f_vpage;
        logic [PA_W-1:0]   f_ppage;
        psz_e              f_size;
        logic              f_w;
        logic              f_u;
        logic              f_nx;
        logic              f_g;
        logic              f_pat;
    } walk_t;

    walk_t q, d;

    mode_e            in_mode;
    logic [PA_W-1:0]  first_addr;
    logic [PA_W-1:0]  step_addr;
    lvl_e             step_lvl;

    logic             ev_present, ev_fault, ev_leaf, ev_perm, ev_wb;
    logic             ev_w, ev_u, ev_nx, ev_g, ev_pat;
    psz_e             ev_psz;
    logic [PA_W-1:0]  ev_next, ev_page;
    logic [ENT_W-1:0] ev_wdata;

    assign in_mode  = mode_e'(mode_i);
    assign step_lvl = lvl_e'(q.lvl - 2'd1);

    pgw_addr u_root_addr (
        .mode (in_mode),
        .lvl  (first_lvl(in_mode)),
        .va   (va_i),
        .base (root_base(in_mode, root_i)),
        .addr (first_addr)
    );

    pgw_addr u_step_addr (
        .mode (q.mode),
        .lvl  (step_lvl),
        .va   (q.va),
        .base (ev_next),
        .addr (step_addr)
    );

    pgw_eval u_eval (
        .mode      (q.mode),
        .lvl       (q.lvl),
        .raw       (mem_rdata_i),
        .nx_on     (q.nx_on),
        .fetch     (q.fetch),
        .present   (ev_present),
        .fault     (ev_fault),
        .leaf      (ev_leaf),
        .psz       (ev_psz),
        .perm_lvl  (ev_perm),
        .need_wb   (ev_wb),
        .ent_w     (ev_w),
        .ent_u     (ev_u),
        .ent_nx    (ev_nx),
        .ent_g     (ev_g),
        .ent_pat   (ev_pat),
        .next_base (ev_next),
        .page_base (ev_page),
        .wb_data   (ev_wdata)
    );

    always_comb begin
        logic nw, nu, nnx;
        d      = q;
        d.done = 1'b0;
        nw     = q.acc_w;
        nu     = q.acc_u;
        nnx    = q.acc_nx;
        case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.st     = S_RD;
                    d.mode   = in_mode;
                    d.lvl    = first_lvl(in_mode);
                    d.va     = (in_mode == MD_LONG) ? va_i : VA_W'(va_i[31:0]);
                    d.addr   = first_addr;
                    d.fetch  = fetch_i;
                    d.wr     = write_i;
                    d.usr    = user_i;
                    d.nx_on  = nx_en_i && ((in_mode == MD_PAE) || (in_mode == MD_LONG));
                    d.uc     = root_i[BIT_CD];
                    d.acc_w  = 1'b1;
                    d.acc_u  = 1'b1;
                    d.acc_nx = 1'b0;
                    d.fault  = 1'b0;
                end
            end
            S_RD: begin
                if (mem_ack_i) begin
                    if (ev_fault) begin
                        d.st        = S_IDLE;
                        d.done      = 1'b1;
                        d.fault     = 1'b1;
                        d.f_present = ev_present;
                        d.f_fetch   = q.fetch && q.nx_on;
                    end else begin
                        if (ev_perm) begin
                            nw  = q.acc_w & ev_w;
                            nu  = q.acc_u & ev_u;
                            nnx = q.acc_nx | ev_nx;
                        end
                        d.acc_w  = nw;
                        d.acc_u  = nu;
                        d.acc_nx = nnx;
                        if (ev_leaf) begin
                            d.f_ppage = ev_page;
                            d.f_vpage = q.va & page_mask(ev_psz);
                            d.f_size  = ev_psz;
                            d.f_w     = nw;
                            d.f_u     = nu;
                            d.f_nx    = nnx;
                            d.f_g     = ev_g;
                            d.f_pat   = ev_pat;
                        end
                        d.nxt_addr = step_addr;
                        d.nxt_lvl  = step_lvl;
                        d.wb_last  = ev_leaf;
                        if (ev_wb) begin
                            d.st    = S_WB;
                            d.wdata = ev_wdata;
                        end else if (ev_leaf) begin
                            d.st    = S_IDLE;
                            d.done  = 1'b1;
                        end else begin
                            d.addr  = step_addr;
                            d.lvl   = step_lvl;
                        end
                    end
                end
            end
            S_WB: begin
                if (mem_ack_i) begin
                    if (q.wb_last) begin
                        d.st   = S_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.st   = S_RD;
                        d.addr = q.nxt_addr;
                        d.lvl  = q.nxt_lvl;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ready_o       = (q.st == S_IDLE);
    assign mem_req_o     = (q.st != S_IDLE);
    assign mem_we_o      = (q.st == S_WB);
    assign mem_uc_o      = q.uc;
    assign mem_addr_o    = q.addr;
    assign mem_wdata_o   = q.wdata;
    assign done_o        = q.done;
    assign fault_o       = q.fault;
    assign flt_present_o = q.f_present;
    assign flt_write_o   = q.wr;
    assign flt_user_o    = q.usr;
    assign flt_fetch_o   = q.f_fetch;
    assign fill_valid_o  = q.done && !q.fault;
    assign fill_vpage_o  = q.f_vpage;
    assign fill_ppage_o  = q.f_ppage;
    assign fill_size_o   = q.f_size;
    assign fill_wr_o     = q.f_w;
    assign fill_user_o   = q.f_u;
    assign fill_nx_o     = q.f_nx;
    assign fill_global_o = q.f_g;
    assign fill_pat_o    = q.f_pat;
    assign fill_uc_o     = q.uc;

endmodule

// File: rtl/pgw_checker.sv
module pgw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        ready_o,
    input logic        done_o,
    input logic        fault_o,
    input logic        fill_valid_o,
    input logic        mem_req_o,
    input logic        mem_we_o,
    input logic        mem_ack_i,
    input logic [51:0] mem_addr_o,
    input logic [63:0] mem_wdata_o
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> ready_o && !mem_req_o && !done_o && !fill_valid_o);

    assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_we_o)
            && $stable(mem_addr_o) && $stable(mem_wdata_o));

    assert_done_when_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ready_o && !mem_req_o);

    assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_fill_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid_o |-> done_o && !fault_o);

    assert_wb_sets_accessed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_we_o |-> mem_wdata_o[5]);

endmodule

bind pgw_top pgw_checker u_pgw_checker (.*);

// File: tb/pgw_top_bench.sv
module pgw_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic [63:0] root_i = '0;
    logic        nx_en_i = 1'b0;
    logic [47:0] va_i = '0;
    logic        fetch_i = 1'b0, write_i = 1'b0, user_i = 1'b0;
    logic        ready_o, mem_req_o, mem_we_o, mem_uc_o;
    logic [51:0] mem_addr_o;
    logic [63:0] mem_wdata_o;
    logic        mem_ack_i = 1'b0;
    logic [63:0] mem_rdata_i = '0;
    logic        done_o, fault_o, flt_present_o, flt_write_o, flt_user_o, flt_fetch_o;
    logic        fill_valid_o;
    logic [47:0] fill_vpage_o;
    logic [51:0] fill_ppage_o;
    logic [1:0]  fill_size_o;
    logic        fill_wr_o, fill_user_o, fill_nx_o, fill_global_o, fill_pat_o, fill_uc_o;

    always #10 clk = ~clk;

    pgw_top u_pgw_top (.*);

    typedef struct {
        logic        fault, pres, fwr, fusr, ffetch;
        logic [51:0] ppage;
        logic [47:0] vpage;
        logic [1:0]  size;
        logic        w, u, nx, g, pat, uc;
        int          nwr;
    } exp_t;

    exp_t sb[$];
    logic [63:0] mem [logic [51:0]];
    int n_tests = 0, n_fail = 0;
    int nwr = 0, rd_bad = 0, wb_bad = 0, uc_bad = 0;
    logic cur_uc = 1'b0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model: one-cycle acknowledge
    always @(posedge clk) begin
        if (mem_req_o && !mem_ack_i) begin
            mem_ack_i <= 1'b1;
            if (mem_uc_o !== cur_uc) uc_bad++;
            if (!mem.exists(mem_addr_o)) begin
                rd_bad++;
                mem_rdata_i <= '0;
            end else if (mem_we_o) begin
                nwr++;
                if (mem_wdata_o !== (mem[mem_addr_o] | 64'h20)) wb_bad++;
                mem[mem_addr_o] = mem_wdata_o;
            end else begin
                mem_rdata_i <= mem[mem_addr_o];
            end
        end else begin
            mem_ack_i <= 1'b0;
        end
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb.size() == 0) begin
                chk("R12 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk("R12 ready with done", ready_o, 1);
                chk("R8 fault", fault_o, e.fault);
                chk("R12 fill_valid", fill_valid_o, !e.fault);
                chk("R6 writeback count", nwr, e.nwr);
                chk("R6 writeback data", wb_bad, 0);
                chk("R2 R4 R5 entry addresses", rd_bad, 0);
                chk("R11 mem_uc", uc_bad, 0);
                if (e.fault) begin
                    chk("R8 R9 flt_present", flt_present_o, e.pres);
                    chk("R8 flt_write", flt_write_o, e.fwr);
                    chk("R8 flt_user", flt_user_o, e.fusr);
                    chk("R9 flt_fetch", flt_fetch_o, e.ffetch);
                end else begin
                    chk("R2 R3 ppage", fill_ppage_o, e.ppage);
                    chk("R10 vpage", fill_vpage_o, e.vpage);
                    chk("R3 size", fill_size_o, e.size);
                    chk("R7 writable", fill_wr_o, e.w);
                    chk("R7 user", fill_user_o, e.u);
                    chk("R7 R9 nx", fill_nx_o, e.nx);
                    chk("R10 global", fill_global_o, e.g);
                    chk("R10 pat", fill_pat_o, e.pat);
                    chk("R11 fill_uc", fill_uc_o, e.uc);
                end
            end
        end
    end

    function automatic logic [63:0] bidx(int md, int pos, logic [47:0] va);
        if (md == 3) begin
            case (pos)
                3: return 64'(va[47:39]);
                2: return 64'(va[38:30]);
                1: return 64'(va[29:21]);
                default: return 64'(va[20:12]);
            endcase
        end else if (md == 2) begin
            case (pos)
                2: return 64'(va[31:30]);
                1: return 64'(va[29:21]);
                default: return 64'(va[20:12]);
            endcase
        end else begin
            return (pos == 1) ? 64'(va[31:22]) : 64'(va[21:12]);
        end
    endfunction

    // driver: build tables, push expectation, launch
    task automatic walk(input int md, input logic [63:0] root, input logic [47:0] va,
                        input logic fe, input logic wr, input logic us, input logic nxe,
                        input logic big, input logic poke, input logic [63:0] fl [4]);
        exp_t e;
        logic [63:0] base, ent, leafb, addr;
        int start, leafpos, k;
        bit stop, nxon;
        mem.delete();
        start   = (md == 3) ? 3 : (md == 2) ? 2 : 1;
        leafpos = big ? 1 : 0;
        if (md == 3)      base = root & 64'h000F_FFFF_FFFF_F000;
        else if (md == 2) base = root & 64'hFFFF_FFE0;
        else              base = root & 64'hFFFF_F000;
        if (big) leafb = (md >= 2) ? 64'h0000_0089_ABC0_0000 : 64'h00C0_0000;
        else     leafb = (md >= 2) ? 64'h0000_0123_4567_8000 : 64'h0ABC_D000;
        e = '{fault:0, pres:0, fwr:wr, fusr:us, ffetch:0, ppage:'0, vpage:'0, size:'0,
              w:1, u:1, nx:0, g:0, pat:0, uc:root[4], nwr:0};
        nxon = nxe && (md >= 2);
        stop = 0;
        k = 0;
        for (int pos = start; pos >= leafpos; pos--) begin
            bit pdp;
            addr = base + bidx(md, pos, va) * ((md >= 2) ? 8 : 4);
            if (pos == leafpos) ent = leafb | fl[k] | (big ? 64'h80 : 64'h0);
            else                ent = (64'h0010_0000 * (k + 1)) | fl[k];
            mem[addr[51:0]] = ent;
            base = 64'h0010_0000 * (k + 1);
            pdp = (md == 2) && (pos == 2);
            if (!stop) begin
                if (!ent[0] || (nxon && fe && ent[63] && !pdp)) begin
                    stop = 1;
                    e.fault = 1;
                    e.pres = ent[0];
                    e.ffetch = fe && nxon;
                end else begin
                    if (!pdp) begin
                        e.w = e.w & ent[1];
                        e.u = e.u & ent[2];
                        e.nx = e.nx | (nxon & ent[63]);
                        if (!ent[5]) e.nwr++;
                    end
                    if (pos == leafpos) begin
                        logic [47:0] v32;
                        e.ppage = leafb[51:0];
                        e.size = big ? ((md >= 2) ? 2'd1 : 2'd2) : 2'd0;
                        v32 = (md == 3) ? va : {16'h0, va[31:0]};
                        e.vpage = v32 & ~(big ? ((md >= 2) ? 48'h1F_FFFF : 48'h3F_FFFF) : 48'hFFF);
                        e.g = ent[8];
                        e.pat = big ? ent[12] : ent[7];
                    end
                end
            end
            k++;
        end
        sb.push_back(e);
        nwr = 0; rd_bad = 0; wb_bad = 0; uc_bad = 0;
        cur_uc = root[4];
        @(negedge clk);
        mode_i = md[1:0]; root_i = root; va_i = va; fetch_i = fe; write_i = wr;
        user_i = us; nx_en_i = nxe; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            @(negedge clk);
            start_i = 1'b1; va_i = 48'h0; mode_i = 2'd0;   // R12: must be ignored mid-walk
            @(negedge clk);
            start_i = 1'b0;
        end
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", ready_o, 1);
        chk("R1 no request in reset", mem_req_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", ready_o, 1);
        chk("R1 no done after reset", done_o, 0);
        chk("R1 no fill after reset", fill_valid_o, 0);

        // R2: 64-bit, 4 KB, every accessed bit clear
        walk(3, 64'h0000_0007_8000_0000, 48'h7F12_3456_7ABC, 0, 1, 1, 0, 0, 0,
             '{64'h7, 64'h7, 64'h7, 64'h7});
        // R6 R7 R10 R12: mixed accessed bits, one level read-only, global + PAT, restart poke
        walk(3, 64'h0000_0007_8000_0000, 48'h0123_4567_8FED, 0, 0, 1, 0, 0, 1,
             '{64'h27, 64'h25, 64'h07, 64'h187});
        // R3: 2 MB leaf with large-page PAT, supervisor-only leaf
        walk(3, 64'h0000_0001_2000_0000, 48'h5555_AAAA_1234, 0, 0, 0, 0, 1, 0,
             '{64'h7, 64'h7, 64'h1023, 64'h0});
        // R8: not present at second level
        walk(3, 64'h0000_0007_8000_0000, 48'h1111_2222_3333, 0, 1, 1, 0, 0, 0,
             '{64'h7, 64'h6, 64'h7, 64'h7});
        // R9: fetch through no-execute directory entry, enabled
        walk(3, 64'h0000_0007_8000_0000, 48'h0F0F_0F0F_0F0F, 1, 0, 0, 1, 0, 0,
             '{64'h27, 64'h27, 64'h8000_0000_0000_0027, 64'h27});
        // R9: same walk with no-execute disabled
        walk(3, 64'h0000_0007_8000_0000, 48'h0F0F_0F0F_0F0F, 1, 0, 0, 0, 0, 0,
             '{64'h27, 64'h27, 64'h8000_0000_0000_0027, 64'h27});
        // R7: data access through no-execute leaf, enabled
        walk(3, 64'h0000_0007_8000_0000, 48'h0ABC_DEF0_1234, 0, 1, 0, 1, 0, 0,
             '{64'h27, 64'h27, 64'h27, 64'h8000_0000_0000_0027});
        // R4: PAE 4 KB, first level present-only and never written
        walk(2, 64'h0000_0000_1234_56E0, 48'h0000_C123_4567, 0, 0, 0, 0, 0, 0,
             '{64'h1, 64'h7, 64'h7, 64'h0});
        // R3 R10 R11: PAE 2 MB, cache disable, upper VA discarded
        walk(2, 64'h0000_0000_0ABC_D010, 48'hFFFF_C0DE_1234, 1, 0, 1, 1, 1, 0,
             '{64'h1, 64'h5, 64'h0, 64'h0});
        // R3 R5 R10: legacy with large pages, 4 MB leaf, global + PAT
        walk(1, 64'h0000_0000_0003_0000, 48'hABCD_9876_5432, 0, 1, 0, 0, 1, 0,
             '{64'h1107, 64'h0, 64'h0, 64'h0});
        // R3 R5: legacy without large pages ignores bit 7 at the directory
        walk(0, 64'h0000_0000_0003_0000, 48'h0000_1357_9BDF, 0, 0, 1, 0, 0, 0,
             '{64'hA7, 64'h07, 64'h0, 64'h0});
        // R8 R9: legacy fault on fetch, fetch flag stays clear
        walk(0, 64'h0000_0000_0004_0000, 48'h0000_2468_ACE0, 1, 0, 1, 1, 0, 0,
             '{64'h07, 64'h06, 64'h0, 64'h0});

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule